// File: doc/BRIEF.md
# DAC Ramp Self-Test Sequencer with Section Sums

This block runs the offline linearity measurement of an on-chip DAC. When the system allows it, it drives the DAC under test with every input code from zero upward. It also enables a 1-bit sigma-delta modulator that digitises the DAC output. While each code is held, the block counts the ones in the modulator bitstream over a chosen number of samples. It adds that count to one of four running sums. The code range is cut into four equal quarters, and the top two code bits select the quarter. A later fitting stage reads the four sums to derive a low-order error polynomial. Only aggregate sums leave the block; no per-code transfer curve is stored.

A run may start only while the system reports idle and the DSP's digital self-test has finished. It can therefore be triggered once at power-up and again at intervals during idle periods to refresh the sums. The modulator enable is held low whenever no run is in progress, so normal operation never sees the converter path active. If the idle indication drops during a run, the run is abandoned and the sums from the last complete run remain on the outputs.

Top module: `dac_ramp_sectsum`

## Requirements
- R1: After reset, `dac_code` is 0, `mod_en` is 0, `done` is 0 and every section sum is 0.
- R2: A run starts at a clock edge where `start_req`, `sys_idle` and `bist_done` are all high and no run is active. A `start_req` at any other time has no effect: the modulator stays off before a run, and an active run continues unchanged.
- R3: During a run, `dac_code` begins at 0 and rises by exactly one after every N sampled bits, ending at 2^CODE_W-1. N is `spc_cfg` captured when the run starts. A captured value of 0 selects the parameter DEF_SPC (64 by default).
- R4: `mod_en` is high exactly while a run is active. Whenever `mod_en` is low, `dac_code` is 0.
- R5: While `mod_en` is high, `mod_bit` is sampled on every clock edge. The ones counted for a code are added to the section sum with index `dac_code[CODE_W-1:CODE_W-2]`, and section k occupies bits [k*ACC_W +: ACC_W] of `sect_sum`.
- R6: Each section sum is ACC_W = CODE_W-2+SPC_W bits wide. An all-ones bitstream yields exactly 2^(CODE_W-2)*N in every section, with no wrap.
- R7: The four sums update together at the clock edge that takes the final sample of code 2^CODE_W-1. `done` is high for exactly that one following cycle. The new sums reflect only the current run.
- R8: If `sys_idle` is low at an edge during a run, the run ends at that edge: `mod_en` falls, `dac_code` returns to 0, `done` stays low and the sums keep their earlier values. This applies even when that edge takes the final sample of the last code.
- R9: After a run completes or is abandoned, the block accepts a new start under the R2 conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to begin a measurement run |
| bist_done | input | 1 | DSP digital self-test has completed |
| sys_idle | input | 1 | System is idle; low aborts a run |
| spc_cfg | input | SPC_W | Samples per code; 0 selects DEF_SPC |
| mod_bit | input | 1 | Sigma-delta modulator output bit |
| dac_code | output | CODE_W | Code applied to the DAC under test |
| mod_en | output | 1 | Modulator enable, high only during a run |
| done | output | 1 | One-cycle pulse when a run completes |
| sect_sum | output | 4*ACC_W | Four section sums, section k at [k*ACC_W +: ACC_W] |

## Verification
Two events can fall in the same cycle: the final sample of the last code, which publishes the sums, and a drop of `sys_idle`, which aborts the run. The bench provokes this by watching its own reference model and lowering `sys_idle` in the cycle just before that last sample edge. It then expects no `done` pulse, unchanged sums, and `mod_en` low. A second overlap is a new `start_req` arriving during a run, which must leave the ramp undisturbed.

// File: rtl/dac_ramp_sectsum_pkg.sv
package dac_ramp_sectsum_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  // Accumulator width: codes per section times the largest sample count.
  function automatic int unsigned acc_width(int unsigned code_w,
                                            int unsigned sect_log2,
                                            int unsigned spc_w);
    return code_w - sect_log2 + spc_w;
  endfunction

  // Effective samples per code: zero selects the default.
  function automatic int unsigned eff_spc(int unsigned cfg, int unsigned def_spc);
    return (cfg == 0) ? def_spc : cfg;
  endfunction

  // Section index of a code: its top sect_log2 bits.
  function automatic int unsigned sect_of(int unsigned code,
                                          int unsigned code_w,
                                          int unsigned sect_log2);
    return code >> (code_w - sect_log2);
  endfunction

endpackage

// File: rtl/dac_ramp_ctrl.sv
module dac_ramp_ctrl
  import dac_ramp_sectsum_pkg::*;
#(
  parameter int unsigned CODE_W    = 14,
  parameter int unsigned SECT_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic                 bist_done,
  input  logic                 sys_idle,
  input  logic                 code_end,
  output logic                 run,
  output logic [CODE_W-1:0]    dac_code,
  output logic [SECT_LOG2-1:0] sect_idx,
  output logic                 run_start,
  output logic                 run_abort,
  output logic                 run_finish,
  output logic                 done
);

  seq_state_t        state_q;
  logic [CODE_W-1:0] code_q;
  logic              last_code;

  assign run       = (state_q == ST_RUN);
  assign last_code = &code_q;
  assign run_start = (state_q == ST_IDLE) && start_req && sys_idle && bist_done;
  assign run_abort = run && !sys_idle;
  // Abort wins over completion in the same cycle.
  assign run_finish = run && sys_idle && code_end && last_code;

  assign dac_code = code_q;
  assign sect_idx = SECT_LOG2'(sect_of(32'(code_q), CODE_W, SECT_LOG2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= run_finish;
      unique case (state_q)
        ST_IDLE: begin
          code_q <= '0;
          if (run_start) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (run_abort) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
          end else if (code_end) begin
            if (last_code) begin
              state_q <= ST_IDLE;
              code_q  <= '0;
            end else begin
              code_q <= code_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dac_ramp_meter.sv
module dac_ramp_meter
  import dac_ramp_sectsum_pkg::*;
#(
  parameter int unsigned SPC_W   = 7,
  parameter int unsigned DEF_SPC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             run_start,
  input  logic             mod_bit,
  input  logic [SPC_W-1:0] spc_cfg,
  output logic             code_end,
  output logic [SPC_W-1:0] code_ones
);

  logic [SPC_W-1:0] spc_q;   // samples per code for this run
  logic [SPC_W-1:0] cnt_q;   // samples already taken for the current code
  logic [SPC_W-1:0] ones_q;  // ones among them

  assign code_end  = run && (cnt_q == spc_q - 1'b1);
  assign code_ones = ones_q + SPC_W'(mod_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spc_q  <= SPC_W'(1);
      cnt_q  <= '0;
      ones_q <= '0;
    end else if (run_start) begin
      spc_q  <= SPC_W'(eff_spc(32'(spc_cfg), DEF_SPC));
      cnt_q  <= '0;
      ones_q <= '0;
    end else if (run) begin
      if (code_end) begin
        cnt_q  <= '0;
        ones_q <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        ones_q <= code_ones;
      end
    end
  end

endmodule

// File: rtl/dac_ramp_bank.sv
module dac_ramp_bank #(
  parameter int unsigned SECT_LOG2 = 2,
  parameter int unsigned SPC_W     = 7,
  parameter int unsigned ACC_W     = 19,
  localparam int unsigned NUM_SECT = 1 << SECT_LOG2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               run_start,
  input  logic                               code_end,
  input  logic                               run_finish,
  input  logic [SECT_LOG2-1:0]               sect_idx,
  input  logic [SPC_W-1:0]                   code_ones,
  output logic [NUM_SECT-1:0][ACC_W-1:0]     sect_sum
);

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    logic [ACC_W-1:0] work_q;
    logic [ACC_W-1:0] pub_q;
    logic             hit;
    logic [ACC_W-1:0] work_nxt;

    assign hit      = code_end && (sect_idx == SECT_LOG2'(g));
    assign work_nxt = work_q + (hit ? ACC_W'(code_ones) : '0);

    // Working sum, cleared at each run start.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         work_q <= '0;
      else if (run_start) work_q <= '0;
      else if (hit)       work_q <= work_nxt;
    end

    // Published sum, replaced only when a run completes.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pub_q <= '0;
      else if (run_finish) pub_q <= work_nxt;
    end

    assign sect_sum[g] = pub_q;
  end

endmodule

// File: rtl/dac_ramp_sectsum.sv
module dac_ramp_sectsum
  import dac_ramp_sectsum_pkg::*;
#(
  parameter int unsigned CODE_W   = 14,
  parameter int unsigned SPC_W    = 7,
  parameter int unsigned DEF_SPC  = 64,
  localparam int unsigned SECT_LOG2 = 2,
  localparam int unsigned NUM_SECT  = 1 << SECT_LOG2,
  localparam int unsigned ACC_W     = acc_width(CODE_W, SECT_LOG2, SPC_W)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_req,
  input  logic                           bist_done,
  input  logic                           sys_idle,
  input  logic [SPC_W-1:0]               spc_cfg,
  input  logic                           mod_bit,
  output logic [CODE_W-1:0]              dac_code,
  output logic                           mod_en,
  output logic                           done,
  output logic [NUM_SECT-1:0][ACC_W-1:0] sect_sum
);

  // Internal events, named for the checker.
  logic                 run;
  logic                 run_start;
  logic                 run_abort;
  logic                 run_finish;
  logic                 code_end;
  logic [SECT_LOG2-1:0] sect_idx;
  logic [SPC_W-1:0]     code_ones;

  assign mod_en = run;

  dac_ramp_ctrl #(
    .CODE_W    (CODE_W),
    .SECT_LOG2 (SECT_LOG2)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .bist_done  (bist_done),
    .sys_idle   (sys_idle),
    .code_end   (code_end),
    .run        (run),
    .dac_code   (dac_code),
    .sect_idx   (sect_idx),
    .run_start  (run_start),
    .run_abort  (run_abort),
    .run_finish (run_finish),
    .done       (done)
  );

  dac_ramp_meter #(
    .SPC_W   (SPC_W),
    .DEF_SPC (DEF_SPC)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .run_start (run_start),
    .mod_bit   (mod_bit),
    .spc_cfg   (spc_cfg),
    .code_end  (code_end),
    .code_ones (code_ones)
  );

  dac_ramp_bank #(
    .SECT_LOG2 (SECT_LOG2),
    .SPC_W     (SPC_W),
    .ACC_W     (ACC_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_start  (run_start),
    .code_end   (code_end),
    .run_finish (run_finish),
    .sect_idx   (sect_idx),
    .code_ones  (code_ones),
    .sect_sum   (sect_sum)
  );

endmodule

// File: rtl/dac_ramp_sectsum_chk.sv
module dac_ramp_sectsum_chk #(
  parameter int unsigned CODE_W   = 14,
  parameter int unsigned NUM_SECT = 4,
  parameter int unsigned ACC_W    = 19
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           start_req,
  input logic                           bist_done,
  input logic                           sys_idle,
  input logic [CODE_W-1:0]              dac_code,
  input logic                           mod_en,
  input logic                           done,
  input logic [NUM_SECT-1:0][ACC_W-1:0] sect_sum,
  input logic                           code_end,
  input logic                           run_finish
);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> (dac_code == '0));

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_en) |-> $past(start_req && sys_idle && bist_done));

  assert_run_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && sys_idle && !run_finish) |=> mod_en);

  assert_code_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && $past(mod_en) && (dac_code != $past(dac_code)))
      |-> (dac_code == $past(dac_code) + 1'b1));

  assert_sample_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_end |-> mod_en);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mod_en && dac_code == '0));

  assert_finish_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_finish |=> done);

  assert_sums_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sect_sum));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !sys_idle) |=> (!mod_en && !done));

endmodule

bind dac_ramp_sectsum dac_ramp_sectsum_chk #(
  .CODE_W   (CODE_W),
  .NUM_SECT (NUM_SECT),
  .ACC_W    (ACC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_req  (start_req),
  .bist_done  (bist_done),
  .sys_idle   (sys_idle),
  .dac_code   (dac_code),
  .mod_en     (mod_en),
  .done       (done),
  .sect_sum   (sect_sum),
  .code_end   (code_end),
  .run_finish (run_finish)
);

// File: tb/tb_dac_ramp_sectsum.sv
`timescale 1ns/1ps
module tb_dac_ramp_sectsum;

  localparam int CODE_W  = 6;
  localparam int SPC_W   = 4;
  localparam int DEF_SPC = 5;
  localparam int NSECT   = 4;
  localparam int ACC_W   = CODE_W - 2 + SPC_W;
  localparam int NCODES  = 1 << CODE_W;
  localparam int PER_SEC = NCODES / NSECT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic bist_done = 1'b0;
  logic sys_idle = 1'b0;
  logic [SPC_W-1:0] spc_cfg = '0;
  logic mod_bit = 1'b0;
  logic [CODE_W-1:0] dac_code;
  logic mod_en;
  logic done;
  logic [NSECT-1:0][ACC_W-1:0] sect_sum;

  always #4 clk = ~clk;  // 125 MHz

  dac_ramp_sectsum #(.CODE_W(CODE_W), .SPC_W(SPC_W), .DEF_SPC(DEF_SPC)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .bist_done(bist_done),
    .sys_idle(sys_idle), .spc_cfg(spc_cfg), .mod_bit(mod_bit),
    .dac_code(dac_code), .mod_en(mod_en), .done(done), .sect_sum(sect_sum));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on the same edges as the design.
  bit m_run = 0;
  int m_code = 0, m_cnt = 0, m_ones = 0, m_spc = 1;
  bit m_done = 0;
  int m_work[NSECT];
  int m_pub[NSECT];
  int ones_seen = 0;   // ones sampled during the current run

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_code = 0; m_cnt = 0; m_ones = 0; m_done = 0;
      foreach (m_work[i]) begin m_work[i] = 0; m_pub[i] = 0; end
    end else begin
      m_done = 0;
      if (m_run) begin
        if (!sys_idle) begin
          m_run = 0; m_code = 0;
        end else begin
          m_ones += mod_bit;
          ones_seen += mod_bit;
          m_cnt++;
          if (m_cnt == m_spc) begin
            m_work[m_code / PER_SEC] += m_ones;
            m_ones = 0; m_cnt = 0;
            if (m_code == NCODES - 1) begin
              foreach (m_pub[i]) m_pub[i] = m_work[i];
              m_done = 1; m_run = 0; m_code = 0;
            end else m_code++;
          end
        end
      end else if (start_req && sys_idle && bist_done) begin
        m_run = 1; m_code = 0; m_cnt = 0; m_ones = 0; ones_seen = 0;
        m_spc = (spc_cfg == 0) ? DEF_SPC : int'(spc_cfg);
        foreach (m_work[i]) m_work[i] = 0;
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(dac_code) == m_code, "R3 dac_code", dac_code, m_code);
      chk(mod_en == m_run, "R4 mod_en", mod_en, m_run);
      chk(done == m_done, "R7 done", done, m_done);
      for (int i = 0; i < NSECT; i++)
        chk(int'(sect_sum[i]) == m_pub[i], "R5 section sum", sect_sum[i], m_pub[i]);
    end
  end

  // Bitstream source: 0 = pseudo-random, 1 = all ones, 2 = alternating.
  int pat = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (pat)
      1: mod_bit <= 1'b1;
      2: mod_bit <= ~mod_bit;
      default: mod_bit <= lfsr[0];
    endcase
  end

  int cyc = 0;
  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic kick(input logic [SPC_W-1:0] spc);
    @(negedge clk);
    spc_cfg = spc; start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  int saved[NSECT];
  bit seen;
  int total;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dac_code == '0, "R1 dac_code", dac_code, 0);
    chk(mod_en == 1'b0, "R1 mod_en", mod_en, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(sect_sum == '0, "R1 sums", sect_sum, 0);
    rst_n = 1'b1;

    // R2: start without completed DSP self-test is ignored
    sys_idle = 1'b1;
    kick(4'd3);
    repeat (4) @(negedge clk);
    chk(mod_en == 1'b0, "R2 no start before bist", mod_en, 0);
    // R2: start while not idle is ignored
    bist_done = 1'b1; sys_idle = 1'b0;
    kick(4'd3);
    repeat (4) @(negedge clk);
    chk(mod_en == 1'b0, "R2 no start when busy", mod_en, 0);
    sys_idle = 1'b1;

    // R3/R5: pseudo-random stream, 3 samples per code, extra start mid-run
    pat = 0;
    kick(4'd3);
    repeat (40) @(negedge clk);
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    chk(mod_en == 1'b1, "R2 restart ignored in run", mod_en, 1);
    wait_done(seen);
    chk(seen, "R7 done after random run", seen, 1);
    total = 0;
    for (int i = 0; i < NSECT; i++) total += int'(sect_sum[i]);
    chk(total == ones_seen, "R5 sum of sections", total, ones_seen);

    // R3: zero selects the default count; alternating stream
    pat = 2;
    kick(4'd0);
    wait_done(seen);
    chk(seen, "R3 default count run done", seen, 1);

    // R6: all ones at the largest count, no wrap
    pat = 1;
    kick(4'd15);
    wait_done(seen);
    chk(seen, "R6 full run done", seen, 1);
    for (int i = 0; i < NSECT; i++)
      chk(int'(sect_sum[i]) == PER_SEC * 15, "R6 full-scale section", sect_sum[i], PER_SEC * 15);

    // R8: abort mid-run keeps previous sums
    for (int i = 0; i < NSECT; i++) saved[i] = int'(sect_sum[i]);
    pat = 0;
    kick(4'd2);
    repeat (50) @(negedge clk);
    sys_idle = 1'b0;
    @(negedge clk);
    chk(mod_en == 1'b0, "R8 abort stops modulator", mod_en, 0);
    chk(dac_code == '0, "R8 abort code zero", dac_code, 0);
    sys_idle = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NSECT; i++)
      chk(int'(sect_sum[i]) == saved[i], "R8 sums kept after abort", sect_sum[i], saved[i]);

    // R8: abort on the very edge of the last sample
    kick(4'd1);
    while (!(m_run && m_code == NCODES - 1 && m_cnt == m_spc - 1)) @(negedge clk);
    sys_idle = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8 abort beats finish", done, 0);
    chk(mod_en == 1'b0, "R8 abort at last sample", mod_en, 0);
    sys_idle = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NSECT; i++)
      chk(int'(sect_sum[i]) == saved[i], "R8 sums kept at coincidence", sect_sum[i], saved[i]);

    // R9: a new run after abort completes normally
    pat = 2;
    kick(4'd4);
    wait_done(seen);
    chk(seen, "R9 run after abort completes", seen, 1);
    for (int i = 0; i < NSECT; i++)
      chk(int'(sect_sum[i]) == PER_SEC * 2, "R9 alternating section", sect_sum[i], PER_SEC * 2);

    repeat (4) @(negedge clk);
    report();
  end

endmodule